// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Status Flags

This block is the purely combinational arithmetic and logic unit of a small accumulator-based processor. On each cycle it takes a 4-bit operation select, a register operand `a` and a memory operand `m`, together with the current carry, zero, overflow and negative bits. It returns the operation result, the full set of outgoing flag bits and a mask that names the flags the operation has changed.

Flags outside the mask are passed through unchanged. The enclosing datapath can therefore load `flags_out` into its status register on every executed operation. The `result_we` output tells the datapath whether `y` should be written back to a register. Compare, bit-test and the unused select codes leave `result_we` low and hold `y` at `a`.

Arithmetic is binary only. Subtraction adds the complement of `m`, with carry in and carry out both meaning "no borrow". Shifts, rotates, increment and decrement all operate on `a`, and `m` is ignored for them. Flag bit layout in `flags_in`, `flags_out` and `flag_mask`: bit 0 carry, bit 1 zero, bit 2 overflow, bit 3 negative.

Top module: `acc_alu`

## Requirements
- R1: With `op`=0 (add), `y` = (a + m + C) mod 256, carry out is set when the 9-bit sum exceeds 0xFF, overflow = bit 7 of ((m ^ y) & (y ^ a)); mask = 4'b1111, `result_we`=1.
- R2: With `op`=1 (subtract), the add of R1 is applied to ~m, so the carry out is 1 exactly when no borrow occurred, and overflow uses ~m in place of m; mask = 4'b1111, `result_we`=1.
- R3: For every operation that writes a result, zero is set exactly when `y` is 0x00 and negative equals `y[7]`.
- R4: With `op`=2 (AND), 3 (OR) or 4 (XOR), `y` is the bitwise result; only zero and negative change (mask 4'b1010), and carry and overflow are copied from `flags_in`.
- R5: With `op`=5 (compare), carry = (a >= m) unsigned, and zero and negative come from (a - m) mod 256; overflow is kept, mask = 4'b1011, `result_we`=0 and `y` = a.
- R6: With `op`=6 (bit-test), zero = ((a & m) == 0), negative = m[7], overflow = m[6]; carry is kept, mask = 4'b1110, `result_we`=0 and `y` = a.
- R7: With `op`=9 (shift left) `y` = a << 1 and carry = a[7]; with `op`=10 (shift right) `y` = a >> 1 and carry = a[0]. In both cases the vacated bit is filled with 0 and the mask is 4'b1011.
- R8: With `op`=11 (rotate left) `y` = {a[6:0], C} and carry = a[7]; with `op`=12 (rotate right) `y` = {C, a[7:1]} and carry = a[0]. The mask is 4'b1011.
- R9: With `op`=7 (increment) `y` = (a + 1) mod 256, and with `op`=8 (decrement) `y` = (a - 1) mod 256; only zero and negative change (mask 4'b1010).
- R10: Select codes 13 to 15 change nothing: mask 0, `flags_out` = `flags_in`, `result_we`=0 and `y` = a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation select |
| a | input | 8 | Register operand |
| m | input | 8 | Memory operand |
| flags_in | input | 4 | Incoming flags {N,V,Z,C} |
| y | output | 8 | Result, equals `a` when nothing is written |
| flags_out | output | 4 | Outgoing flags {N,V,Z,C} |
| flag_mask | output | 4 | Flags changed by this operation |
| result_we | output | 1 | `y` is to be written back |

## Verification
Carry and signed overflow can both be raised by a single add or subtract, and zero can be raised in the same cycle as well. The bench provokes this with 0x80 + 0x80, which must set carry, overflow and zero together with a 0x00 result. It also provokes it with 0x50 - 0xB0, which must set overflow and negative while clearing carry. Each flag is judged separately against the sign-disagreement rule and the 9-bit sum, so a design that lets one flag mask the other is caught.

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] y,
  output logic [3:0]   flags_out,
  output logic [3:0]   flag_mask,
  output logic         result_we
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
                         OP_XOR = 4'd4, OP_CMP = 4'd5, OP_BIT = 4'd6, OP_INC = 4'd7,
                         OP_DEC = 4'd8, OP_SHL = 4'd9, OP_SHR = 4'd10, OP_ROL = 4'd11,
                         OP_ROR = 4'd12;
  localparam logic [3:0] MSK_ALL = 4'b1111, MSK_ZN = 4'b1010, MSK_CZN = 4'b1011,
                         MSK_ZVN = 4'b1110, MSK_NONE = 4'b0000;

  wire          cin   = flags_in[0];
  wire [W-1:0]  addend = (op == OP_SUB) ? ~m : m;
  wire [W:0]    sum   = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin};
  wire [W-1:0]  sres  = sum[W-1:0];
  wire          sovf  = ((addend ^ sres) & (sres ^ a)) >> MSB != '0;
  wire [W:0]    cdiff = {1'b0, a} - {1'b0, m};

  logic [W-1:0] fsrc;
  logic         c_new, v_new, z_new, n_new;

  always_comb begin
    y         = a;
    fsrc      = a;
    c_new     = cin;
    v_new     = flags_in[2];
    flag_mask = MSK_NONE;
    result_we = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        y = sres; fsrc = sres; c_new = sum[W]; v_new = sovf;
        flag_mask = MSK_ALL; result_we = 1'b1;
      end
      OP_AND: begin y = a & m; fsrc = a & m; flag_mask = MSK_ZN; result_we = 1'b1; end
      OP_OR:  begin y = a | m; fsrc = a | m; flag_mask = MSK_ZN; result_we = 1'b1; end
      OP_XOR: begin y = a ^ m; fsrc = a ^ m; flag_mask = MSK_ZN; result_we = 1'b1; end
      OP_CMP: begin
        fsrc = cdiff[W-1:0]; c_new = ~cdiff[W]; flag_mask = MSK_CZN;
      end
      OP_BIT: begin
        fsrc = a & m; v_new = m[MSB-1]; flag_mask = MSK_ZVN;
      end
      OP_INC: begin y = a + 1'b1; fsrc = a + 1'b1; flag_mask = MSK_ZN; result_we = 1'b1; end
      OP_DEC: begin y = a - 1'b1; fsrc = a - 1'b1; flag_mask = MSK_ZN; result_we = 1'b1; end
      OP_SHL: begin
        y = {a[MSB-1:0], 1'b0}; fsrc = {a[MSB-1:0], 1'b0}; c_new = a[MSB];
        flag_mask = MSK_CZN; result_we = 1'b1;
      end
      OP_SHR: begin
        y = {1'b0, a[MSB:1]}; fsrc = {1'b0, a[MSB:1]}; c_new = a[0];
        flag_mask = MSK_CZN; result_we = 1'b1;
      end
      OP_ROL: begin
        y = {a[MSB-1:0], cin}; fsrc = {a[MSB-1:0], cin}; c_new = a[MSB];
        flag_mask = MSK_CZN; result_we = 1'b1;
      end
      OP_ROR: begin
        y = {cin, a[MSB:1]}; fsrc = {cin, a[MSB:1]}; c_new = a[0];
        flag_mask = MSK_CZN; result_we = 1'b1;
      end
      default: ;
    endcase
  end

  assign z_new = (fsrc == '0);
  assign n_new = (op == OP_BIT) ? m[MSB] : fsrc[MSB];

  assign flags_out[0] = flag_mask[0] ? c_new : flags_in[0];
  assign flags_out[1] = flag_mask[1] ? z_new : flags_in[1];
  assign flags_out[2] = flag_mask[2] ? v_new : flags_in[2];
  assign flags_out[3] = flag_mask[3] ? n_new : flags_in[3];

  always_comb begin
    if (op == OP_ADD)
      assert_add_carry_R1: assert (flags_out[0] == ((int'(a) + int'(m) + int'(cin)) > (2**W - 1)))
        else $error("add carry mismatch");
    if (op == OP_SUB)
      assert_sub_borrow_R2: assert (flags_out[0] == ((int'(a) + int'(cin)) > int'(m)))
        else $error("subtract borrow mismatch");
    if (result_we && flag_mask[1])
      assert_zero_rule_R3: assert (flags_out[1] == (y == '0) && flags_out[3] == y[MSB])
        else $error("zero/negative rule broken");
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      assert_logic_keeps_cv_R4: assert (flags_out[0] == flags_in[0] && flags_out[2] == flags_in[2])
        else $error("logic op touched carry or overflow");
    if (op == OP_CMP)
      assert_cmp_no_write_R5: assert (!result_we && y == a && flags_out[0] == (a >= m))
        else $error("compare wrote a result or wrong carry");
    if (op == OP_BIT)
      assert_bit_copies_R6: assert (flags_out[3] == m[MSB] && flags_out[2] == m[MSB-1] && !result_we)
        else $error("bit-test flag copy wrong");
    if (op == OP_ROL)
      assert_rol_feed_R8: assert (y[0] == cin) else $error("rotate left feed wrong");
    if (op == OP_ROR)
      assert_ror_feed_R8: assert (y[MSB] == cin) else $error("rotate right feed wrong");
    if (op == OP_INC)
      assert_inc_wrap_R9: assert (W'(y - a) == W'(1)) else $error("increment not modular");
    if (op > OP_ROR)
      assert_reserved_idle_R10: assert (flag_mask == '0 && flags_out == flags_in && !result_we && y == a)
        else $error("reserved code changed state");
  end
endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] op = '0;
  logic [7:0] a = '0, m = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] y;
  logic [3:0] flags_out, flag_mask;
  logic       result_we;

  acc_alu #(.W(8)) dut (.op(op), .a(a), .m(m), .flags_in(flags_in), .y(y),
                        .flags_out(flags_out), .flag_mask(flag_mask), .result_we(result_we));

  int n_tests = 0;
  int n_fail  = 0;

  localparam int NV = 23;
  localparam logic [40:0] VECS [0:NV-1] = '{
    {4'd0,  8'h50, 8'h50, 4'h0, 8'hA0, 4'hC, 4'hF, 1'b1},
    {4'd0,  8'hFF, 8'h01, 4'h1, 8'h01, 4'h1, 4'hF, 1'b1},
    {4'd0,  8'hFF, 8'h01, 4'h0, 8'h00, 4'h3, 4'hF, 1'b1},
    {4'd1,  8'h50, 8'hB0, 4'h1, 8'hA0, 4'hC, 4'hF, 1'b1},
    {4'd1,  8'h05, 8'h05, 4'h1, 8'h00, 4'h3, 4'hF, 1'b1},
    {4'd1,  8'h05, 8'h05, 4'h0, 8'hFF, 4'h8, 4'hF, 1'b1},
    {4'd2,  8'hF0, 8'h3C, 4'h5, 8'h30, 4'h5, 4'hA, 1'b1},
    {4'd3,  8'h00, 8'h00, 4'h0, 8'h00, 4'h2, 4'hA, 1'b1},
    {4'd4,  8'hFF, 8'h7F, 4'h4, 8'h80, 4'hC, 4'hA, 1'b1},
    {4'd5,  8'h40, 8'h40, 4'h4, 8'h40, 4'h7, 4'hB, 1'b0},
    {4'd5,  8'h10, 8'h20, 4'h0, 8'h10, 4'h8, 4'hB, 1'b0},
    {4'd6,  8'h0F, 8'hC0, 4'h1, 8'h0F, 4'hF, 4'hE, 1'b0},
    {4'd6,  8'hFF, 8'h01, 4'h0, 8'hFF, 4'h0, 4'hE, 1'b0},
    {4'd7,  8'hFF, 8'h00, 4'h5, 8'h00, 4'h7, 4'hA, 1'b1},
    {4'd8,  8'h00, 8'h00, 4'h0, 8'hFF, 4'h8, 4'hA, 1'b1},
    {4'd9,  8'h81, 8'h00, 4'h0, 8'h02, 4'h1, 4'hB, 1'b1},
    {4'd10, 8'h01, 8'h00, 4'h1, 8'h00, 4'h3, 4'hB, 1'b1},
    {4'd11, 8'h80, 8'h00, 4'h1, 8'h01, 4'h1, 4'hB, 1'b1},
    {4'd11, 8'h40, 8'h00, 4'h0, 8'h80, 4'h8, 4'hB, 1'b1},
    {4'd12, 8'h01, 8'h00, 4'h0, 8'h00, 4'h3, 4'hB, 1'b1},
    {4'd12, 8'h02, 8'h00, 4'h1, 8'h81, 4'h8, 4'hB, 1'b1},
    {4'd13, 8'h5A, 8'h11, 4'h6, 8'h5A, 4'h6, 4'h0, 1'b0},
    {4'd15, 8'h5A, 8'h11, 4'h6, 8'h5A, 4'h6, 4'h0, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R9";
      4'd9, 4'd10: return "R7";
      4'd11, 4'd12: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] av, input logic [7:0] mv,
                       input logic [3:0] fv);
    @(posedge clk);
    op = o; a = av; m = mv; flags_in = fv;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] ey, input logic [3:0] ef,
                       input logic [3:0] em, input logic ew);
    n_tests++;
    if (y !== ey || flags_out !== ef || flag_mask !== em || result_we !== ew) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h m=%h: y=%h flags=%b mask=%b we=%b, expected y=%h flags=%b mask=%b we=%b",
               req, op, a, m, y, flags_out, flag_mask, result_we, ey, ef, em, ew);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R3", 8'h00, 4'h2, 4'hF, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][40:37], VECS[i][36:29], VECS[i][28:21], VECS[i][20:17]);
      check(tag_of(VECS[i][40:37]), VECS[i][16:9], VECS[i][8:5], VECS[i][4:1], VECS[i][0]);
    end

    // R1: carry, overflow and zero together
    apply(4'd0, 8'h80, 8'h80, 4'h0);
    check("R1", 8'h00, 4'h7, 4'hF, 1'b1);
    // R1: carry-in alone pushes the sum past 0xFF
    apply(4'd0, 8'hFE, 8'h01, 4'h1);
    check("R1", 8'h00, 4'h3, 4'hF, 1'b1);
    // R5: register below memory clears carry, keeps overflow
    apply(4'd5, 8'h00, 8'hFF, 4'h4);
    check("R5", 8'h00, 4'h4, 4'hB, 1'b0);
    // R10: reserved code 14 with all flags set
    apply(4'd14, 8'hC3, 8'h3C, 4'hF);
    check("R10", 8'hC3, 4'hF, 4'h0, 1'b0);

    // R9 and R3: increment sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = 8'(v + 1);
      apply(4'd7, 8'(v), 8'h00, 4'h5);
      check("R9", e, {e[7], 1'b1, (e == 8'h00), 1'b1}, 4'hA, 1'b1);
    end
    // R3 and R8: rotate right sweep with carry 1
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = {1'b1, 7'(v >> 1)};
      apply(4'd12, 8'(v), 8'h00, 4'h1);
      check("R8", e, {1'b1, 1'b0, 1'b0, v[0]}, 4'hB, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule